// File: doc/BRIEF.md
# One-Time-Programmable Fuse Word Programmer

This block programs a single 32-bit word of a one-time-programmable fuse array per request. Software first loads the timing register. It then writes the control register with the target word number and the unlock key, which may go in the same access. A write to the data register then starts the operation. The controller reads the word's present fuse contents and drops every bit that is already blown from the request. It then walks the remaining bits out of the data register one at a time, least significant first, shifting right with zero fill. Each bit step is paced by the programmed strobe and relax counts.

A behavioural fuse array sits inside the block. Which words are locked is a parameter. A request aimed at a locked word, or at a word number beyond the array, blows nothing and sets the error flag instead. That flag must be cleared through the clear alias before the block accepts anything again. When busy drops, a programmable quiet counter holds a pending flag high, and during that interval new requests are also refused. The fuse contents can be read back through a word window on the bus.

Top module: `fuse_prog_ctrl`

## Requirements
- R1: After reset the control word (offset 0x000), the timing word (offset 0x010) and the data word (offset 0x020) all read 0, and busy, error and quiet_pending are low.
- R2: The control word holds the target word number in [7:0], busy in bit 8, error in bit 9, a reload flag in bit 10 and the unlock field in [31:16]. A plain write at 0x000 replaces the number, reload and unlock fields and leaves busy and error untouched. A write at 0x004 ORs ones into those fields. A write at 0x008 clears the fields whose bits are one, and clears error when bit 9 is one.
- R3: A data write is a start request when unlock equals 0x3E77, busy, error and quiet_pending are all low, and the target is not locked. A start raises busy on the next cycle and clears the unlock field. It also latches the target, so control writes made while busy do not change which word is programmed.
- R4: Once the read phase ends, the data word holds the request AND NOT the current fuse word. When busy falls, the fuse word equals its old value OR the request. Fuse bits never return to 0.
- R5: While busy, the data word shifts right with zero fill once per bit step, and bus writes to it are ignored. It reads 0 when the operation completes.
- R6: The timing word holds the strobe count in [11:0], the relax count in [15:12], the read count in [21:16] and the quiet count in [27:22]. These values are captured at start. Busy then stays high for exactly (read+1) + 32*(strobe+relax+1) cycles.
- R7: A start request whose target is locked, or whose target number is not below WORDS, sets error, clears the unlock field, does not raise busy and leaves the array unchanged.
- R8: While error is set, a data write carrying a valid unlock key starts nothing. Once error has been cleared through 0x008, the same request is accepted. Busy and error are never high together.
- R9: A data write when the unlock field is not 0x3E77 sets neither busy nor error and changes no fuse.
- R10: When busy falls, quiet_pending stays high for exactly the captured quiet count of cycles (none when it is 0). Data writes during that interval start nothing.
- R11: Fuse word w reads back at byte offset 0x400 + 0x10*w. Window offsets for words at or above WORDS read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| busy | output | 1 | Programming in progress (mirror of control bit 8) |
| error | output | 1 | Error flag (mirror of control bit 9) |
| quiet_pending | output | 1 | Post-program quiet interval running |

## Verification
The bench goes after the corner cases where a plausible design slips. It changes the target number while busy: a design that failed to latch the address would burn the new word. It programs over bits that are already blown and checks the masked data word in the gap between the read phase and the first shift. A design that skipped the mask would show the raw request there. It writes the data word during busy, during error and during the quiet interval, and requires that nothing starts and nothing shifts. It measures busy and quiet lengths exactly under three timing settings, so a step counter that is off by one cycle shows up as a length mismatch. A locked word and an out-of-range target must each raise error without busy and without touching the array.

// File: rtl/fuse_prog_pkg.sv
package fuse_prog_pkg;

   localparam logic [15:0] UNLOCK_KEY = 16'h3E77;

   localparam int FUSE_W  = 32;
   localparam int BIT_W   = 5;
   localparam int TADR_W  = 8;
   localparam int WIN_W   = 6;

   localparam int OFS_CTRL   = 'h000;
   localparam int OFS_SET    = 'h004;
   localparam int OFS_CLR    = 'h008;
   localparam int OFS_TIMING = 'h010;
   localparam int OFS_DATA   = 'h020;
   localparam int WIN_BASE   = 'h400;

   localparam int POS_BUSY   = 8;
   localparam int POS_ERR    = 9;
   localparam int POS_RELOAD = 10;

   typedef struct packed {
      logic [5:0]  quiet;
      logic [5:0]  rd;
      logic [3:0]  relax;
      logic [11:0] prog;
   } timing_t;

   localparam int TIM_W = $bits(timing_t);
   localparam int CNT_W = 13;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_READ = 2'd1,
      SQ_STEP = 2'd2
   } seq_state_t;

endpackage

// File: rtl/fuse_array.sv
module fuse_array import fuse_prog_pkg::*; #(
   parameter int               WORDS     = 16,
   parameter logic [WORDS-1:0] LOCK_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              burn_en,
   input  logic [TADR_W-1:0] burn_word,
   input  logic [BIT_W-1:0]  burn_bit,
   input  logic [TADR_W-1:0] lk_addr,
   output logic              lk_locked,
   input  logic [TADR_W-1:0] rd_addr,
   output logic [FUSE_W-1:0] rd_data,
   input  logic [WIN_W-1:0]  win_idx,
   output logic [FUSE_W-1:0] win_data
);

   localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

   if (WORDS < 2 || WORDS > 64) begin : g_bad_words
      $error("fuse_array: WORDS must lie in 2..64");
   end

   logic [FUSE_W-1:0] word_q [WORDS];

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [FUSE_W-1:0] cell_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cell_q <= '0;
         end else if (burn_en && int'(burn_word) == w) begin
            cell_q[burn_bit] <= 1'b1;
         end
      end

      assign word_q[w] = cell_q;

      // fuse bits only ever go from 0 to 1
      assert_fuse_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(cell_q) & ~cell_q) == '0);
   end

   logic lk_in_rng, rd_in_rng, win_in_rng;
   assign lk_in_rng  = int'(lk_addr) < WORDS;
   assign rd_in_rng  = int'(rd_addr) < WORDS;
   assign win_in_rng = int'(win_idx) < WORDS;

   assign lk_locked = !lk_in_rng || LOCK_MASK[lk_addr[IDX_W-1:0]];
   assign rd_data   = rd_in_rng  ? word_q[rd_addr[IDX_W-1:0]] : '0;
   assign win_data  = win_in_rng ? word_q[win_idx[IDX_W-1:0]] : '0;

endmodule

// File: rtl/fuse_seq.sv
module fuse_seq import fuse_prog_pkg::*; (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [TADR_W-1:0] tgt_in,
   input  timing_t           tim,
   input  logic              data_we,
   input  logic [FUSE_W-1:0] wdata,
   input  logic [FUSE_W-1:0] fuse_rd,
   output logic [TADR_W-1:0] tgt_addr,
   output logic [FUSE_W-1:0] data_q,
   output logic              busy,
   output logic              burn_en,
   output logic [BIT_W-1:0]  burn_bit,
   output logic              quiet_pending
);

   seq_state_t        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  step_m1_q;
   logic [5:0]        quiet_len_q;
   logic [5:0]        quiet_q;
   logic [BIT_W-1:0]  bit_q;

   logic step_end, last_bit;
   assign step_end = (state_q == SQ_STEP) && (cnt_q == '0);
   assign last_bit = (bit_q == BIT_W'(FUSE_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= SQ_IDLE;
         cnt_q       <= '0;
         step_m1_q   <= '0;
         quiet_len_q <= '0;
         quiet_q     <= '0;
         bit_q       <= '0;
         data_q      <= '0;
         tgt_addr    <= '0;
      end else begin
         if (quiet_q != '0) quiet_q <= quiet_q - 6'd1;
         unique case (state_q)
            SQ_IDLE: begin
               if (start) begin
                  data_q      <= wdata;
                  tgt_addr    <= tgt_in;
                  cnt_q       <= CNT_W'(tim.rd);
                  step_m1_q   <= CNT_W'(tim.prog) + CNT_W'(tim.relax);
                  quiet_len_q <= tim.quiet;
                  state_q     <= SQ_READ;
               end else if (data_we) begin
                  data_q <= wdata;
               end
            end
            SQ_READ: begin
               if (cnt_q == '0) begin
                  data_q  <= data_q & ~fuse_rd;
                  cnt_q   <= step_m1_q;
                  bit_q   <= '0;
                  state_q <= SQ_STEP;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            SQ_STEP: begin
               if (cnt_q == '0) begin
                  data_q <= {1'b0, data_q[FUSE_W-1:1]};
                  if (last_bit) begin
                     state_q <= SQ_IDLE;
                     quiet_q <= quiet_len_q;
                  end else begin
                     bit_q <= bit_q + 1'b1;
                     cnt_q <= step_m1_q;
                  end
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy          = (state_q != SQ_IDLE);
   assign burn_en       = step_end && data_q[0];
   assign burn_bit      = bit_q;
   assign quiet_pending = (quiet_q != '0);

   // between steps the data word must hold regardless of bus writes
   assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_STEP && cnt_q != '0) |=> $stable(data_q));

   // quiet interval follows every completion with a nonzero count
   assert_quiet_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && quiet_len_q != '0) |-> quiet_pending);

   // no start can come out of a quiet interval
   assert_no_start_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$past(quiet_pending));

endmodule

// File: rtl/fuse_prog_ctrl.sv
module fuse_prog_ctrl import fuse_prog_pkg::*; #(
   parameter int               ADDR_W     = 12,
   parameter int               WORDS      = 16,
   parameter logic [WORDS-1:0] LOCK_MASK  = WORDS'(8'h88),
   parameter logic [TIM_W-1:0] TIMING_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              busy,
   output logic              error,
   output logic              quiet_pending
);

   if (WIN_BASE + 16 * WORDS > (1 << ADDR_W) || ADDR_W < 11) begin : g_bad_addr
      $error("fuse_prog_ctrl: ADDR_W too small for the fuse window");
   end

   // ---------------- decode ----------------
   logic hit_ctrl, hit_set, hit_clr, hit_tim, hit_data;
   assign hit_ctrl = bus_we && bus_addr == ADDR_W'(OFS_CTRL);
   assign hit_set  = bus_we && bus_addr == ADDR_W'(OFS_SET);
   assign hit_clr  = bus_we && bus_addr == ADDR_W'(OFS_CLR);
   assign hit_tim  = bus_we && bus_addr == ADDR_W'(OFS_TIMING);
   assign hit_data = bus_we && bus_addr == ADDR_W'(OFS_DATA);

   logic in_win;
   assign in_win = (bus_addr[ADDR_W-1:10] == (ADDR_W-10)'(1)) && (bus_addr[3:0] == 4'd0);

   // ---------------- registers ----------------
   logic [TADR_W-1:0] tadr_q;
   logic              reload_q;
   logic [15:0]       unlock_q;
   logic              error_q;
   timing_t           tim_q;

   logic              tgt_locked;
   logic              req_ok, start, lock_err;
   logic [FUSE_W-1:0] data_q, fuse_rd, win_data;
   logic [TADR_W-1:0] tgt_addr;
   logic              burn_en;
   logic [BIT_W-1:0]  burn_bit;

   assign req_ok   = hit_data && (unlock_q == UNLOCK_KEY) && !busy && !error_q && !quiet_pending;
   assign start    = req_ok && !tgt_locked;
   assign lock_err = req_ok && tgt_locked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tadr_q   <= '0;
         reload_q <= 1'b0;
         unlock_q <= '0;
         error_q  <= 1'b0;
         tim_q    <= timing_t'(TIMING_RST);
      end else begin
         if (hit_ctrl) begin
            tadr_q   <= bus_wdata[TADR_W-1:0];
            reload_q <= bus_wdata[POS_RELOAD];
            unlock_q <= bus_wdata[31:16];
         end
         if (hit_set) begin
            tadr_q   <= tadr_q | bus_wdata[TADR_W-1:0];
            reload_q <= reload_q | bus_wdata[POS_RELOAD];
            unlock_q <= unlock_q | bus_wdata[31:16];
         end
         if (hit_clr) begin
            tadr_q   <= tadr_q & ~bus_wdata[TADR_W-1:0];
            reload_q <= reload_q & ~bus_wdata[POS_RELOAD];
            unlock_q <= unlock_q & ~bus_wdata[31:16];
            if (bus_wdata[POS_ERR]) error_q <= 1'b0;
         end
         if (hit_tim) tim_q <= timing_t'(bus_wdata[TIM_W-1:0]);
         if (start || lock_err) unlock_q <= '0;
         if (lock_err) error_q <= 1'b1;
      end
   end

   // ---------------- submodules ----------------
   fuse_array #(
      .WORDS     (WORDS),
      .LOCK_MASK (LOCK_MASK)
   ) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .burn_en   (burn_en),
      .burn_word (tgt_addr),
      .burn_bit  (burn_bit),
      .lk_addr   (tadr_q),
      .lk_locked (tgt_locked),
      .rd_addr   (tgt_addr),
      .rd_data   (fuse_rd),
      .win_idx   (bus_addr[9:4]),
      .win_data  (win_data)
   );

   fuse_seq u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .tgt_in        (tadr_q),
      .tim           (tim_q),
      .data_we       (hit_data),
      .wdata         (bus_wdata),
      .fuse_rd       (fuse_rd),
      .tgt_addr      (tgt_addr),
      .data_q        (data_q),
      .busy          (busy),
      .burn_en       (burn_en),
      .burn_bit      (burn_bit),
      .quiet_pending (quiet_pending)
   );

   // ---------------- read mux ----------------
   logic [31:0] ctrl_view;
   assign ctrl_view = {unlock_q, 5'd0, reload_q, error_q, busy, tadr_q};

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_CTRL) || bus_addr == ADDR_W'(OFS_SET) ||
          bus_addr == ADDR_W'(OFS_CLR))        bus_rdata = ctrl_view;
      else if (bus_addr == ADDR_W'(OFS_TIMING)) bus_rdata = 32'(tim_q);
      else if (bus_addr == ADDR_W'(OFS_DATA))   bus_rdata = data_q;
      else if (in_win)                          bus_rdata = win_data;
   end

   assign error = error_q;

   logic unused_wbits;
   assign unused_wbits = ^{bus_wdata[15:11], bus_wdata[8]};

   // a start always consumes the unlock key
   assert_unlock_consumed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> unlock_q == '0);

   // error and busy exclude each other
   assert_busy_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && error_q));

   // a rejected locked target never starts the engine
   assert_lock_no_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(error_q) |-> !busy);

endmodule

// File: tb/tb_fuse_prog_ctrl.sv
module tb_fuse_prog_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        busy, error, pend;

   always #5 clk = ~clk;

   fuse_prog_ctrl dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .bus_we        (bus_we),
      .bus_addr      (bus_addr),
      .bus_wdata     (bus_wdata),
      .bus_rdata     (bus_rdata),
      .busy          (busy),
      .error         (error),
      .quiet_pending (pend)
   );

   int n_tot = 0;
   int n_bad = 0;
   bit done  = 0;

   typedef struct { int busy_cyc; int quiet_cyc; } exp_t;
   exp_t sb_q[$];

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_tot++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
      bus_addr = '0;
   endtask

   function automatic int busy_len(int prog, int relax, int rdc);
      return (rdc + 1) + 32 * (prog + relax + 1);
   endfunction

   // driver: start a program request that is expected to run
   task automatic launch(int word, logic [31:0] d, int prog, int relax, int rdc, int q);
      exp_t e;
      e.busy_cyc  = busy_len(prog, relax, rdc);
      e.quiet_cyc = q;
      sb_q.push_back(e);
      wr(12'h000, {16'h3E77, 8'd0, 8'(word)});
      wr(12'h020, d);
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      while (pend) @(negedge clk);
   endtask

   // monitor: measures busy and quiet lengths, compares to scoreboard
   int brun = 0, prun = 0, qexp = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy) brun++;
         else if (brun > 0) begin
            if (sb_q.size() == 0) chk("R6 unexpected completion", 32'(brun), 32'd0);
            else begin
               exp_t e;
               e = sb_q.pop_front();
               chk("R6 busy length", 32'(brun), 32'(e.busy_cyc));
               qexp = e.quiet_cyc;
            end
            brun = 0;
         end
         if (pend) prun++;
         else if (prun > 0) begin
            chk("R10 quiet length", 32'(prun), 32'(qexp));
            prun = 0;
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_tot++; n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_tot, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(12'h000, v); chk("R1 ctrl", v, 32'h0);
      rd(12'h010, v); chk("R1 timing", v, 32'h0);
      rd(12'h020, v); chk("R1 data", v, 32'h0);
      chk("R1 flags", {29'd0, busy, error, pend}, 32'h0);
      rd(12'h420, v); chk("R11 fuse2 blank", v, 32'h0);

      // R9 data write without unlock
      wr(12'h000, 32'h0000_0002);
      wr(12'h020, 32'h0000_FFFF);
      repeat (5) @(negedge clk);
      chk("R9 flags", {30'd0, busy, error}, 32'h0);
      rd(12'h420, v); chk("R9 fuse untouched", v, 32'h0);

      // R2 control aliases
      wr(12'h000, 32'h1234_075A);
      rd(12'h000, v); chk("R2 plain write", v, 32'h1234_045A);
      wr(12'h004, 32'h0000_0021);
      rd(12'h004, v); chk("R2 set alias", v, 32'h1234_047B);
      wr(12'h008, 32'h1234_0403);
      rd(12'h008, v); chk("R2 clear alias", v, 32'h0000_0078);
      wr(12'h008, 32'hFFFF_FFFF);

      // R6 timing: prog=2 relax=1 rd=1 quiet=5
      wr(12'h010, 32'h0141_1002);
      rd(12'h010, v); chk("R6 timing readback", v, 32'h0141_1002);

      // R3 start, address latch, R5 ignored write
      launch(2, 32'h0000_00F0, 2, 1, 1, 5);
      rd(12'h000, v); chk("R3 busy set, unlock cleared", v, 32'h0000_0102);
      wr(12'h000, 32'h0000_0005);
      wr(12'h020, 32'h0000_DEAD);
      while (busy) @(negedge clk);
      // R10 request during quiet interval
      wr(12'h000, 32'h3E77_0006);
      wr(12'h020, 32'h0000_000F);
      chk("R10 no start in quiet", {31'd0, busy}, 32'h0);
      wait_idle();
      rd(12'h420, v); chk("R3 latched target burned", v, 32'h0000_00F0);
      rd(12'h450, v); chk("R3 moved address untouched", v, 32'h0);
      rd(12'h460, v); chk("R10 quiet request ignored", v, 32'h0);
      wr(12'h008, 32'hFFFF_FFFF);
      wr(12'h020, 32'h0);

      // R4 masking with prog=5 relax=2 rd=3 quiet=3
      wr(12'h010, 32'h00C3_2005);
      launch(2, 32'h0000_0FF0, 5, 2, 3, 3);
      repeat (4) @(negedge clk);
      rd(12'h020, v); chk("R4 masked data", v, 32'h0000_0F00);
      wait_idle();
      rd(12'h020, v); chk("R5 data shifted out", v, 32'h0);
      rd(12'h420, v); chk("R4 fuse OR result", v, 32'h0000_0FF0);

      // minimal timing, quiet 0
      wr(12'h010, 32'h0000_0000);
      launch(4, 32'h8000_0001, 0, 0, 0, 0);
      wait_idle();
      rd(12'h440, v); chk("R11 fuse4 readback", v, 32'h8000_0001);

      // R7 locked word 3
      wr(12'h000, 32'h3E77_0003);
      wr(12'h020, 32'hFFFF_FFFF);
      @(negedge clk);
      chk("R7 busy low", {31'd0, busy}, 32'h0);
      rd(12'h000, v); chk("R7 error set, unlock cleared", v, 32'h0000_0203);
      rd(12'h430, v); chk("R7 locked fuse unchanged", v, 32'h0);

      // R8 blocked while error set
      wr(12'h000, 32'h3E77_0004);
      wr(12'h020, 32'h0000_0010);
      @(negedge clk);
      chk("R8 no start under error", {31'd0, busy}, 32'h0);
      rd(12'h440, v); chk("R8 fuse4 unchanged", v, 32'h8000_0001);
      wr(12'h008, 32'h0000_0200);
      chk("R8 error cleared", {31'd0, error}, 32'h0);
      rd(12'h000, v); chk("R8 key kept", v, 32'h3E77_0004);
      begin
         exp_t e;
         e.busy_cyc = busy_len(0, 0, 0); e.quiet_cyc = 0;
         sb_q.push_back(e);
      end
      wr(12'h020, 32'h0000_0010);
      wait_idle();
      rd(12'h440, v); chk("R8 accepted after clear", v, 32'h8000_0011);

      // R7 out-of-range target
      wr(12'h000, 32'h3E77_0014);
      wr(12'h020, 32'h0000_0001);
      @(negedge clk);
      chk("R7 out-of-range error", {30'd0, busy, error}, 32'h1);
      rd(12'h540, v); chk("R11 window beyond array", v, 32'h0);
      wr(12'h008, 32'hFFFF_FFFF);

      repeat (5) @(negedge clk);
      chk("R6 scoreboard drained", 32'(sb_q.size()), 32'h0);
      done = 1;
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
   end

endmodule